// File: doc/BRIEF.md
# Programmable-Length Shift-Register Noise Source

This block is a pseudo-random bit generator built around a 24-stage Fibonacci shift register. Every enabled clock shifts the register one place toward its most significant end, and a new bit enters stage 0. That bit is the parity of the stages picked out by a run-time tap mask. The parity tree is split into three 8-bit sections, and each section's result feeds the next. A sense input inverts the parity, so the feedback can be XOR or XNOR. The full 24-bit state is brought out in parallel so that downstream logic can use it as a noise word.

The highest set bit of the tap mask sets the active length of the register, anywhere from 1 to 24 stages. Only the stages at or below that bit count as the generator's state. The stages above it just carry a delayed copy of the sequence. A lock-up guard watches the active stages for the one state the chosen sense cannot leave, and forces the opposite bit into stage 0. A registered sync output pulses for one clock each time the active stages return to the seed pattern, which marks the start of the sequence.

Top module: `lfsr_noise_gen`

## Requirements
- R1: A synchronous reset loads the state with the seed 24'h000001 and drives sync_pulse low.
- R2: While enable is low the state holds its value and sync_pulse is low.
- R3: On each enabled clock, state[23:1] takes the old state[22:0]. With sense_xnor=0, state[0] takes the XOR of all old state bits whose tap_mask bit is 1.
- R4: With sense_xnor=1, the bit entering state[0] is the inverse of the parity defined in R3.
- R5: The active length is one more than the index of the highest set tap_mask bit. With the maximal tap sets used in the bench for lengths 2 to 14, the sequence returns to the seed after exactly 2^k-1 enabled clocks, for both senses.
- R6: With sense_xnor=0, an enabled clock that finds all active bits at zero shifts in a 1 instead of the parity bit.
- R7: With sense_xnor=1, an enabled clock that finds all active bits at one shifts in a 0 instead of the inverted parity bit.
- R8: A tap_mask of all zeros gives constant feedback (0 for XOR, 1 for XNOR) and makes all 24 stages active. Starting from reset with XOR sense, the seed comes back after 25 clocks. With XNOR sense, the state reaches 24'hFFFFFF after 23 clocks and 24'hFFFFFE after 24 clocks.
- R9: sync_pulse is high for exactly the clock after an enabled step that leaves the active bits equal to the seed pattern (bit 0 set, the other active bits clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| tap_mask | input | 24 | Feedback tap select; highest set bit sets active length |
| sense_xnor | input | 1 | 1 selects inverted (XNOR) feedback |
| state | output | 24 | Parallel register contents |
| sync_pulse | output | 1 | One-clock marker on return to the seed |

## Verification
The bench goes after the lock-up guard in three ways. It changes the tap mask at run time so that only the active low bits are all zero (or all one), with stale bits still sitting above them. A design that checked the whole word would stay stuck there, or would shift the parity in. The all-zero mask catches a guard that ignores the sense setting: the all-ones state would freeze in XNOR mode, or the 25-clock XOR cycle would break. The sync period is measured for every length from 2 to 14 in both senses. A design that compared the full word against the seed, or took the length from the wrong end of the mask, would give no pulse or a wrong interval.

// File: rtl/lfsr_noise_gen.sv
`timescale 1ns/1ps
module lfsr_noise_gen #(
  parameter int WIDTH = 24,
  parameter int SECT  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] tap_mask,
  input  logic             sense_xnor,
  output logic [WIDTH-1:0] state,
  output logic             sync_pulse
);
  localparam int NSECT = WIDTH / SECT;
  localparam logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] reach, act, nxt;
  logic             par, forb, fb;

  always_comb begin
    reach[WIDTH-1] = tap_mask[WIDTH-1];
    for (int i = WIDTH-2; i >= 0; i--) reach[i] = reach[i+1] | tap_mask[i];
  end

  always_comb begin
    par = sense_xnor;
    for (int s = 0; s < NSECT; s++)
      par = par ^ (^(state[s*SECT +: SECT] & tap_mask[s*SECT +: SECT]));
  end

  assign act  = (|tap_mask) ? reach : '1;
  assign forb = sense_xnor ? ((state & act) == act) : ((state & act) == '0);
  assign fb   = forb ? ~sense_xnor : par;
  assign nxt  = {state[WIDTH-2:0], fb};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEED;
      sync_pulse <= 1'b0;
    end else begin
      if (en) state <= nxt;
      sync_pulse <= en && ((nxt & act) == SEED);
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state) && !sync_pulse);
  // R3
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));
  // R6
  zero_recover_chk: assert property (@(posedge clk) disable iff (rst)
    en && !sense_xnor && forb |=> state[0]);
  // R7
  ones_recover_chk: assert property (@(posedge clk) disable iff (rst)
    en && sense_xnor && forb |=> !state[0]);
  // R9
  sync_step_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> $past(en) && state[0]);
endmodule

// File: tb/test_lfsr_noise_gen.sv
`timescale 1ns/1ps
module test_lfsr_noise_gen;
  logic        clk = 0, rst = 1, en = 0, sense_xnor = 0;
  logic [23:0] tap_mask = '0;
  logic [23:0] state;
  logic        sync_pulse;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lfsr_noise_gen i_lfsr_noise_gen (
    .clk(clk), .rst(rst), .en(en), .tap_mask(tap_mask),
    .sense_xnor(sense_xnor), .state(state), .sync_pulse(sync_pulse));

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] mact(input logic [23:0] m);
    logic [23:0] a = '1;
    for (int i = 0; i < 24; i++) if (m[i]) a = 24'((25'd2 << i) - 25'd1);
    return a;
  endfunction

  function automatic logic [23:0] mstep(input logic [23:0] s, input logic [23:0] m, input logic x);
    logic [23:0] a = mact(m);
    logic b;
    if (x ? ((s & a) == a) : ((s & a) == 24'd0)) b = ~x;
    else b = (^(s & m)) ^ x;
    return {s[22:0], b};
  endfunction

  task automatic do_reset();
    rst = 1; tick(); rst = 0;
  endtask

  task automatic run_lock(input logic [23:0] m, input logic x, input int n, input string req);
    logic [23:0] ms = 24'h000001;
    tap_mask = m; sense_xnor = x; en = 1;
    do_reset();
    for (int i = 0; i < n; i++) begin
      tick();
      ms = mstep(ms, m, x);
      chk(req, state, ms);
      chk({req, " R9 sync"}, {23'd0, sync_pulse}, {23'd0, (ms & mact(m)) == 24'd1});
    end
  endtask

  task automatic measure(input logic [23:0] m, input logic x, input int exp, input string req);
    int cnt = 0;
    tap_mask = m; sense_xnor = x; en = 1;
    do_reset();
    do begin tick(); cnt++; end while (!sync_pulse && cnt < exp + 50);
    chk(req, 24'(cnt), 24'(exp));
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] taps [2:14];
    logic [23:0] held;
    taps[2]  = 24'h0003; taps[3]  = 24'h0006; taps[4]  = 24'h000C;
    taps[5]  = 24'h0014; taps[6]  = 24'h0030; taps[7]  = 24'h0060;
    taps[8]  = 24'h00B8; taps[9]  = 24'h0110; taps[10] = 24'h0240;
    taps[11] = 24'h0500; taps[12] = 24'h0829; taps[13] = 24'h100D;
    taps[14] = 24'h2015;

    // R1
    en = 1; tap_mask = 24'hE10000; tick(); tick(); rst = 0;
    chk("R1 state", state, 24'h000001);
    chk("R1 sync", {23'd0, sync_pulse}, 24'd0);

    // R2
    en = 1; tick(); tick(); tick(); en = 0; held = state;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R2 hold", state, held);
      chk("R2 sync", {23'd0, sync_pulse}, 24'd0);
    end

    // R3 R4: lockstep against model
    run_lock(24'hE10000, 1'b0, 300, "R3 xor");
    run_lock(24'hE10000, 1'b1, 300, "R4 xnor");
    run_lock(24'h5A3C91, 1'b0, 200, "R3 dense");
    run_lock(24'h5A3C91, 1'b1, 200, "R4 dense");
    run_lock(24'h000000, 1'b0, 60,  "R8 zero xor");
    run_lock(24'h000000, 1'b1, 60,  "R8 zero xnor");

    // R5
    for (int k = 2; k <= 14; k++) begin
      measure(taps[k], 1'b0, (1 << k) - 1, $sformatf("R5 xor len %0d", k));
      measure(taps[k], 1'b1, (1 << k) - 1, $sformatf("R5 xnor len %0d", k));
    end

    // R8
    measure(24'h0, 1'b0, 25, "R8 zero-mask period");
    tap_mask = 24'h0; sense_xnor = 1; en = 1; do_reset();
    for (int i = 0; i < 23; i++) tick();
    chk("R8 xnor all ones", state, 24'hFFFFFF);
    tick();
    chk("R8 xnor recover", state, 24'hFFFFFE);

    // R6: active low bits zero, stale bit above
    tap_mask = 24'h0; sense_xnor = 0; en = 1; do_reset();
    for (int i = 0; i < 10; i++) tick();
    chk("R6 pre", state, 24'h000400);
    tap_mask = 24'h00000C; tick();
    chk("R6 inject one", state, 24'h000801);

    // R7: active low bits ones
    tap_mask = 24'h0; sense_xnor = 1; en = 1; do_reset();
    for (int i = 0; i < 3; i++) tick();
    chk("R7 pre", state, 24'h00000F);
    tap_mask = 24'h00000C; tick();
    chk("R7 inject zero", state, 24'h00001E);

    // R9: pulse is one clock wide
    measure(taps[3], 1'b0, 7, "R9 first return");
    tick();
    chk("R9 width", {23'd0, sync_pulse}, 24'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule